// File: doc/BRIEF.md
# Segmented Circular Queue Pointer Manager

This block keeps the read and write pointers for a set of output queues that share one 32K-entry buffer. The buffer is split into 1024-entry regions, and each region is split into 32-entry chunks. A queue is described by a region number and by the first and last chunk it owns inside that region. It therefore holds between 32 and 1024 entries in steps of 32 and never crosses a region boundary. The data storage sits outside this block. The block gives out only the 15-bit entry address that a producer writes to and the address that a consumer reads from.

Each queue keeps a tail (the next write slot), a head (the next read slot) and an occupancy count. The count tells a full queue from an empty one when head and tail are equal. Both pointers move forward one entry per accepted operation. When a pointer leaves the last entry of the last chunk, it jumps back to entry 0 of the first chunk. Requests the block cannot honour are refused with a one-cycle error pulse, and no pointer moves. A configuration port loads a queue's bounds and clears its pointers. It is meant to be used while that queue is idle.

Top module: `cq_ptr_mgr`

## Requirements
- R1: After reset every queue is empty, not full and has no configuration error. Every queue is bounded to region 0, chunks 0 to 0, so its first enqueue address is 0. enq_ok, enq_err, deq_ok and deq_err are low.
- R2: An entry address is {region (bits 14:10), chunk (bits 9:5), entry (bits 4:0)}. An accepted enqueue raises enq_ok for one cycle on the edge after the request. On that same edge enq_addr shows the queue's tail. The tail starts at entry 0 of the first chunk.
- R3: An accepted dequeue raises deq_ok for one cycle on the edge after the request. On that same edge deq_addr shows the queue's head. Entries come out in the order they were written.
- R4: Once a pointer has given out entry 31 of the last chunk, its next address is entry 0 of the first chunk. No address ever leaves the queue's region.
- R5: A queue holds (last − first + 1) × 32 entries. q_full is high when the count equals that capacity. q_empty is high when the count is zero. Both flags update on the edge that accepts an operation.
- R6: An enqueue to a full queue is refused, and so is a dequeue from an empty queue. The refusal is a one-cycle error pulse on the edge after the request, with no ok. The pointers, the count and the address output of that port stay unchanged.
- R7: An enqueue and a dequeue to the same queue in one cycle are both judged against the occupancy before that cycle. Both can succeed, and then the count is unchanged.
- R8: A configuration write sets the queue's bounds and puts head and tail at entry 0 of the new first chunk. It also clears the count. An enqueue or dequeue to that queue in the same cycle is refused with an error pulse.
- R9: A configuration whose last chunk is below its first chunk sets q_cfg_err for that queue. While q_cfg_err is set, q_full stays low and every enqueue and dequeue to that queue is refused with an error pulse. A later valid configuration clears q_cfg_err.
- R10: Queues are independent. An operation or a configuration on one queue never changes another queue's pointers, count or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load bounds into queue cfg_qid |
| cfg_qid | input | 3 | Queue being configured |
| cfg_region | input | 5 | Region number (address bits 14:10) |
| cfg_first | input | 5 | First chunk of the queue |
| cfg_last | input | 5 | Last chunk of the queue |
| enq_vld | input | 1 | Enqueue request |
| enq_qid | input | 3 | Queue for the enqueue |
| deq_vld | input | 1 | Dequeue request |
| deq_qid | input | 3 | Queue for the dequeue |
| enq_ok | output | 1 | Enqueue accepted (one-cycle pulse) |
| enq_err | output | 1 | Enqueue refused (one-cycle pulse) |
| enq_addr | output | 15 | Entry address of the last accepted enqueue |
| deq_ok | output | 1 | Dequeue accepted (one-cycle pulse) |
| deq_err | output | 1 | Dequeue refused (one-cycle pulse) |
| deq_addr | output | 15 | Entry address of the last accepted dequeue |
| q_empty | output | 8 | Per-queue empty flag |
| q_full | output | 8 | Per-queue full flag |
| q_cfg_err | output | 8 | Per-queue invalid-bounds flag |

## Verification
Every result the block produces is registered exactly once. The ok and error pulses, the two address outputs and the empty, full and configuration-error flags all reflect a request on the first rising edge after it is presented. The bench drives requests on the falling edge. Its behavioural model advances on the rising edge that consumes them, and every output is compared against the model on the next falling edge, so each comparison lands exactly one edge after its stimulus. Directed sequences (fill to capacity, wrap-around, same-cycle enqueue and dequeue, reconfiguration clashes, inverted bounds) are followed by a long mixed random run under the same per-cycle comparison.

// File: rtl/cqpm_pkg.sv
package cqpm_pkg;

    // address split: region | chunk | entry
    localparam int ENTRY_W  = 5;
    localparam int SLOT_W   = 5;
    localparam int REGION_W = 5;
    localparam int OFF_W    = ENTRY_W + SLOT_W;
    localparam int ADDR_W   = REGION_W + OFF_W;
    localparam int CNT_W    = OFF_W + 1;

    typedef struct packed {
        logic [REGION_W-1:0] region;
        logic [SLOT_W-1:0]   first;
        logic [SLOT_W-1:0]   last;
    } qbound_t;

    // offset of entry 0 in the first chunk
    function automatic logic [OFF_W-1:0] home_off(qbound_t b);
        return {b.first, {ENTRY_W{1'b0}}};
    endfunction

    // advance a pointer by one entry, wrapping from the last chunk's top entry
    function automatic logic [OFF_W-1:0] step_off(logic [OFF_W-1:0] off, qbound_t b);
        if (off == {b.last, {ENTRY_W{1'b1}}})
            return home_off(b);
        return off + OFF_W'(1);
    endfunction

    // number of entries a well-formed queue holds
    function automatic logic [CNT_W-1:0] span_entries(qbound_t b);
        logic [CNT_W-1:0] chunks;
        chunks = CNT_W'(b.last) - CNT_W'(b.first) + CNT_W'(1);
        return chunks << ENTRY_W;
    endfunction

    function automatic logic bounds_bad(qbound_t b);
        return b.last < b.first;
    endfunction

endpackage

// File: rtl/cqpm_qlane.sv
module cqpm_qlane
    import cqpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  qbound_t           load_bnd,
    input  logic              enq_go,
    input  logic              deq_go,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              empty,
    output logic              full,
    output logic              bad
);

    qbound_t           bnd_q;
    logic              bad_q;
    logic [OFF_W-1:0]  head_q;
    logic [OFF_W-1:0]  tail_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bnd_q  <= '0;
            bad_q  <= 1'b0;
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            bnd_q  <= load_bnd;
            bad_q  <= bounds_bad(load_bnd);
            head_q <= home_off(load_bnd);
            tail_q <= home_off(load_bnd);
            cnt_q  <= '0;
        end else begin
            if (enq_go)
                tail_q <= step_off(tail_q, bnd_q);
            if (deq_go)
                head_q <= step_off(head_q, bnd_q);
            case ({enq_go, deq_go})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign wr_addr = {bnd_q.region, tail_q};
    assign rd_addr = {bnd_q.region, head_q};
    assign empty   = (cnt_q == '0);
    assign full    = !bad_q && (cnt_q == span_entries(bnd_q));
    assign bad     = bad_q;

endmodule

// File: rtl/cqpm_port.sv
module cqpm_port
    import cqpm_pkg::*;
#(
    parameter int NUM_Q = 8,
    parameter int QID_W = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req,
    input  logic [QID_W-1:0]             req_qid,
    input  logic [NUM_Q-1:0]             stop,
    input  logic [NUM_Q-1:0]             bad,
    input  logic                         cfg_we,
    input  logic [QID_W-1:0]             cfg_qid,
    input  logic [NUM_Q-1:0][ADDR_W-1:0] ptr_addr,
    output logic [NUM_Q-1:0]             go,
    output logic                         ok,
    output logic                         err,
    output logic [ADDR_W-1:0]            addr
);

    logic [NUM_Q-1:0]  hit;
    logic              sel_block;
    logic [ADDR_W-1:0] sel_addr;
    logic              accept;

    for (genvar k = 0; k < NUM_Q; k++) begin : g_hit
        assign hit[k] = (req_qid == QID_W'(k));
    end

    always_comb begin
        sel_block = 1'b1;
        sel_addr  = '0;
        for (int k = 0; k < NUM_Q; k++) begin
            if (hit[k]) begin
                sel_block = stop[k] | bad[k];
                sel_addr  = ptr_addr[k];
            end
        end
    end

    assign accept = req && !sel_block && !(cfg_we && (cfg_qid == req_qid));
    assign go     = accept ? hit : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ok   <= 1'b0;
            err  <= 1'b0;
            addr <= '0;
        end else begin
            ok  <= accept;
            err <= req && !accept;
            if (accept)
                addr <= sel_addr;
        end
    end

endmodule

// File: rtl/cq_ptr_mgr.sv
module cq_ptr_mgr
    import cqpm_pkg::*;
#(
    parameter  int NUM_Q = 8,
    localparam int QID_W = $clog2(NUM_Q)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [QID_W-1:0]    cfg_qid,
    input  logic [REGION_W-1:0] cfg_region,
    input  logic [SLOT_W-1:0]   cfg_first,
    input  logic [SLOT_W-1:0]   cfg_last,
    input  logic                enq_vld,
    input  logic [QID_W-1:0]    enq_qid,
    input  logic                deq_vld,
    input  logic [QID_W-1:0]    deq_qid,
    output logic                enq_ok,
    output logic                enq_err,
    output logic [ADDR_W-1:0]   enq_addr,
    output logic                deq_ok,
    output logic                deq_err,
    output logic [ADDR_W-1:0]   deq_addr,
    output logic [NUM_Q-1:0]    q_empty,
    output logic [NUM_Q-1:0]    q_full,
    output logic [NUM_Q-1:0]    q_cfg_err
);

    qbound_t                     new_bnd;
    logic [NUM_Q-1:0]            enq_go;
    logic [NUM_Q-1:0]            deq_go;
    logic [NUM_Q-1:0][ADDR_W-1:0] wr_vec;
    logic [NUM_Q-1:0][ADDR_W-1:0] rd_vec;

    assign new_bnd = '{region: cfg_region, first: cfg_first, last: cfg_last};

    for (genvar k = 0; k < NUM_Q; k++) begin : g_lane
        cqpm_qlane u_lane (
            .clk      (clk),
            .rst      (rst),
            .load     (cfg_we && (cfg_qid == QID_W'(k))),
            .load_bnd (new_bnd),
            .enq_go   (enq_go[k]),
            .deq_go   (deq_go[k]),
            .wr_addr  (wr_vec[k]),
            .rd_addr  (rd_vec[k]),
            .empty    (q_empty[k]),
            .full     (q_full[k]),
            .bad      (q_cfg_err[k])
        );
    end

    cqpm_port #(.NUM_Q(NUM_Q), .QID_W(QID_W)) u_enq_port (
        .clk      (clk),
        .rst      (rst),
        .req      (enq_vld),
        .req_qid  (enq_qid),
        .stop     (q_full),
        .bad      (q_cfg_err),
        .cfg_we   (cfg_we),
        .cfg_qid  (cfg_qid),
        .ptr_addr (wr_vec),
        .go       (enq_go),
        .ok       (enq_ok),
        .err      (enq_err),
        .addr     (enq_addr)
    );

    cqpm_port #(.NUM_Q(NUM_Q), .QID_W(QID_W)) u_deq_port (
        .clk      (clk),
        .rst      (rst),
        .req      (deq_vld),
        .req_qid  (deq_qid),
        .stop     (q_empty),
        .bad      (q_cfg_err),
        .cfg_we   (cfg_we),
        .cfg_qid  (cfg_qid),
        .ptr_addr (rd_vec),
        .go       (deq_go),
        .ok       (deq_ok),
        .err      (deq_err),
        .addr     (deq_addr)
    );

endmodule

// File: rtl/cqpm_chk.sv
module cqpm_chk
    import cqpm_pkg::*;
#(
    parameter int NUM_Q = 8,
    parameter int QID_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [QID_W-1:0]  cfg_qid,
    input logic [SLOT_W-1:0] cfg_first,
    input logic [SLOT_W-1:0] cfg_last,
    input logic              enq_vld,
    input logic [QID_W-1:0]  enq_qid,
    input logic              deq_vld,
    input logic [QID_W-1:0]  deq_qid,
    input logic              enq_ok,
    input logic              enq_err,
    input logic [ADDR_W-1:0] enq_addr,
    input logic              deq_ok,
    input logic              deq_err,
    input logic [ADDR_W-1:0] deq_addr,
    input logic [NUM_Q-1:0]  q_empty,
    input logic [NUM_Q-1:0]  q_full,
    input logic [NUM_Q-1:0]  q_cfg_err
);

    // R6
    enq_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(enq_ok && enq_err));

    // R6
    deq_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(deq_ok && deq_err));

    // R5
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (q_full & q_empty) == '0);

    // R6
    enq_full_chk: assert property (@(posedge clk) disable iff (rst)
        enq_vld && q_full[enq_qid] |=> enq_err && !enq_ok);

    // R6
    deq_empty_chk: assert property (@(posedge clk) disable iff (rst)
        deq_vld && q_empty[deq_qid] |=> deq_err && !deq_ok);

    // R6
    enq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        enq_err |-> $stable(enq_addr));

    // R6
    deq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        deq_err |-> $stable(deq_addr));

    // R8
    cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> q_empty[$past(cfg_qid)]);

    // R8
    cfg_clash_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we && enq_vld && (cfg_qid == enq_qid) |=> enq_err);

    // R9
    cfg_bad_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we && (cfg_last < cfg_first) |=> q_cfg_err[$past(cfg_qid)]);

    // R9
    bad_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        enq_vld && !cfg_we && q_cfg_err[enq_qid] |=> enq_err);

endmodule

bind cq_ptr_mgr cqpm_chk #(.NUM_Q(NUM_Q), .QID_W(QID_W)) u_cqpm_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_qid   (cfg_qid),
    .cfg_first (cfg_first),
    .cfg_last  (cfg_last),
    .enq_vld   (enq_vld),
    .enq_qid   (enq_qid),
    .deq_vld   (deq_vld),
    .deq_qid   (deq_qid),
    .enq_ok    (enq_ok),
    .enq_err   (enq_err),
    .enq_addr  (enq_addr),
    .deq_ok    (deq_ok),
    .deq_err   (deq_err),
    .deq_addr  (deq_addr),
    .q_empty   (q_empty),
    .q_full    (q_full),
    .q_cfg_err (q_cfg_err)
);

// File: tb/test_cq_ptr_mgr.sv
module test_cq_ptr_mgr;

    localparam int NQ = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_qid = '0;
    logic [4:0]  cfg_region = '0;
    logic [4:0]  cfg_first = '0;
    logic [4:0]  cfg_last = '0;
    logic        enq_vld = 1'b0;
    logic [2:0]  enq_qid = '0;
    logic        deq_vld = 1'b0;
    logic [2:0]  deq_qid = '0;
    logic        enq_ok, enq_err, deq_ok, deq_err;
    logic [14:0] enq_addr, deq_addr;
    logic [NQ-1:0] q_empty, q_full, q_cfg_err;

    int n_tests = 0;
    int n_fail  = 0;
    string phase_tag = "R1";

    always #4 clk = ~clk;

    cq_ptr_mgr #(.NUM_Q(NQ)) i_cq_ptr_mgr (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_qid(cfg_qid), .cfg_region(cfg_region),
        .cfg_first(cfg_first), .cfg_last(cfg_last),
        .enq_vld(enq_vld), .enq_qid(enq_qid),
        .deq_vld(deq_vld), .deq_qid(deq_qid),
        .enq_ok(enq_ok), .enq_err(enq_err), .enq_addr(enq_addr),
        .deq_ok(deq_ok), .deq_err(deq_err), .deq_addr(deq_addr),
        .q_empty(q_empty), .q_full(q_full), .q_cfg_err(q_cfg_err)
    );

    // ---------------- behavioural reference ----------------
    int m_reg[NQ], m_first[NQ], m_last[NQ], m_head[NQ], m_tail[NQ], m_cnt[NQ];
    bit m_bad[NQ];
    bit e_enq_ok, e_enq_err, e_deq_ok, e_deq_err;
    int e_enq_addr, e_deq_addr;

    function automatic int cap(int q);
        return (m_last[q] - m_first[q] + 1) * 32;
    endfunction

    function automatic int adv(int q, int off);
        if (off == m_last[q] * 32 + 31) return m_first[q] * 32;
        return off + 1;
    endfunction

    always @(posedge clk) begin
        int qe, qd;
        bit eo, ee, dok, de;
        if (rst) begin
            for (int k = 0; k < NQ; k++) begin
                m_reg[k] = 0; m_first[k] = 0; m_last[k] = 0;
                m_head[k] = 0; m_tail[k] = 0; m_cnt[k] = 0; m_bad[k] = 0;
            end
            e_enq_ok = 0; e_enq_err = 0; e_deq_ok = 0; e_deq_err = 0;
            e_enq_addr = 0; e_deq_addr = 0;
        end else begin
            qe = int'(enq_qid); qd = int'(deq_qid);
            eo = 0; ee = 0; dok = 0; de = 0;
            if (enq_vld) begin
                if ((cfg_we && cfg_qid == enq_qid) || m_bad[qe] || m_cnt[qe] == cap(qe)) ee = 1;
                else begin eo = 1; e_enq_addr = m_reg[qe] * 1024 + m_tail[qe]; end
            end
            if (deq_vld) begin
                if ((cfg_we && cfg_qid == deq_qid) || m_bad[qd] || m_cnt[qd] == 0) de = 1;
                else begin dok = 1; e_deq_addr = m_reg[qd] * 1024 + m_head[qd]; end
            end
            if (eo) begin m_tail[qe] = adv(qe, m_tail[qe]); m_cnt[qe]++; end
            if (dok) begin m_head[qd] = adv(qd, m_head[qd]); m_cnt[qd]--; end
            if (cfg_we) begin
                int c;
                c = int'(cfg_qid);
                m_reg[c] = int'(cfg_region); m_first[c] = int'(cfg_first);
                m_last[c] = int'(cfg_last); m_bad[c] = (cfg_last < cfg_first);
                m_head[c] = m_first[c] * 32; m_tail[c] = m_first[c] * 32; m_cnt[c] = 0;
            end
            e_enq_ok = eo; e_enq_err = ee; e_deq_ok = dok; e_deq_err = de;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string tag, string nm, int got, int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s (%s) %s: actual %0h expected %0h", tag, phase_tag, nm, got, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2", "enq_ok",   int'(enq_ok),   int'(e_enq_ok));
        chk("R6", "enq_err",  int'(enq_err),  int'(e_enq_err));
        chk("R2", "enq_addr", int'(enq_addr), e_enq_addr);
        chk("R3", "deq_ok",   int'(deq_ok),   int'(e_deq_ok));
        chk("R6", "deq_err",  int'(deq_err),  int'(e_deq_err));
        chk("R3", "deq_addr", int'(deq_addr), e_deq_addr);
        for (int k = 0; k < NQ; k++) begin
            chk("R5", $sformatf("q_empty[%0d]", k), int'(q_empty[k]), int'(m_cnt[k] == 0));
            chk("R5", $sformatf("q_full[%0d]", k),  int'(q_full[k]),
                int'(!m_bad[k] && m_cnt[k] == cap(k)));
            chk("R9", $sformatf("q_cfg_err[%0d]", k), int'(q_cfg_err[k]), int'(m_bad[k]));
        end
    endtask

    // one cycle: inputs already driven; wait edge, compare, return to idle
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        cfg_we = 1'b0; enq_vld = 1'b0; deq_vld = 1'b0;
    endtask

    task automatic do_cfg(int q, int r, int f, int l);
        cfg_we = 1'b1; cfg_qid = 3'(q); cfg_region = 5'(r);
        cfg_first = 5'(f); cfg_last = 5'(l);
        step();
    endtask

    task automatic do_enq(int q);
        enq_vld = 1'b1; enq_qid = 3'(q); step();
    endtask

    task automatic do_deq(int q);
        deq_vld = 1'b1; deq_qid = 3'(q); step();
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "empty after reset", int'(q_empty), 255);
        chk("R1", "full after reset", int'(q_full), 0);
        chk("R1", "cfg_err after reset", int'(q_cfg_err), 0);
        chk("R1", "pulses after reset", int'({enq_ok, enq_err, deq_ok, deq_err}), 0);
        do_enq(5);
        chk("R1", "default first address", int'(enq_addr), 0);
        do_deq(5);

        // R4: 32-entry queue, fill, refuse, wrap
        phase_tag = "R4";
        do_cfg(0, 3, 2, 2);
        for (int i = 0; i < 32; i++) do_enq(0);
        chk("R5", "q0 full after 32", int'(q_full[0]), 1);
        do_enq(0);
        chk("R6", "enq to full refused", int'(enq_err), 1);
        chk("R6", "addr held on refusal", int'(enq_addr), 'hC5F);
        do_deq(0);
        chk("R3", "first read addr", int'(deq_addr), 'hC40);
        do_enq(0);
        chk("R4", "tail wrapped to first chunk", int'(enq_addr), 'hC40);
        for (int i = 0; i < 32; i++) do_deq(0);
        chk("R4", "head wrapped to first chunk", int'(deq_addr), 'hC40);
        do_deq(0);
        chk("R6", "deq from empty refused", int'(deq_err), 1);

        // R7: simultaneous enqueue and dequeue
        phase_tag = "R7";
        do_cfg(1, 31, 30, 31);
        enq_vld = 1'b1; enq_qid = 3'd1; deq_vld = 1'b1; deq_qid = 3'd1; step();
        chk("R7", "enq ok with deq on empty", int'(enq_ok), 1);
        chk("R7", "deq refused on empty", int'(deq_err), 1);
        for (int i = 0; i < 80; i++) begin
            enq_vld = 1'b1; enq_qid = 3'd1; deq_vld = 1'b1; deq_qid = 3'd1; step();
        end
        chk("R7", "count unchanged", int'(q_empty[1]), 0);

        // R8: reprogram clears and clashes
        phase_tag = "R8";
        do_enq(0);
        do_cfg(0, 3, 1, 1);
        chk("R8", "reprogram empties", int'(q_empty[0]), 1);
        do_enq(0);
        chk("R8", "restart at new first chunk", int'(enq_addr), 'hC20);
        cfg_we = 1'b1; cfg_qid = 3'd0; cfg_region = 5'd3; cfg_first = 5'd1; cfg_last = 5'd1;
        enq_vld = 1'b1; enq_qid = 3'd0; step();
        chk("R8", "op on queue being configured refused", int'(enq_err), 1);

        // R9: inverted bounds
        phase_tag = "R9";
        do_cfg(2, 7, 5, 4);
        chk("R9", "bad bounds flagged", int'(q_cfg_err[2]), 1);
        do_enq(2);
        chk("R9", "enq to bad queue refused", int'(enq_err), 1);
        do_cfg(2, 7, 4, 5);
        chk("R9", "valid bounds clear flag", int'(q_cfg_err[2]), 0);

        // R10: many queues, random mix
        phase_tag = "R10";
        do_cfg(3, 0, 0, 31);
        do_cfg(4, 9, 10, 12);
        do_cfg(5, 12, 31, 31);
        do_cfg(6, 20, 0, 1);
        do_cfg(7, 1, 3, 3);
        for (int i = 0; i < 6000; i++) begin
            enq_vld = 1'($urandom % 3 != 0); enq_qid = 3'($urandom);
            deq_vld = 1'($urandom % 2);      deq_qid = 3'($urandom);
            if ($urandom % 97 == 0) begin
                cfg_we = 1'b1; cfg_qid = 3'($urandom); cfg_region = 5'($urandom);
                cfg_first = 5'($urandom); cfg_last = 5'($urandom);
            end
            step();
        end
        finish_run();
    end

endmodule